// File: doc/BRIEF.md
# Terminal Receive Channel with Modem Status

This block is the receive side of a single asynchronous terminal line as a host sees it through a 16-bit register bus. A deserializer hands it finished characters or break indications. The block holds the last one in a buffer register, along with error, overrun and break marks. It raises a receive request when a character is waiting and the host has enabled that request.

A strap input picks between a plain line and a line with modem control. With modem control on, the status register also carries ring, clear-to-send, carrier detect and a dataset-change flag. The host drives DTR, RTS and a secondary transmit bit. A change of dataset state raises a second, separate request. When DTR rises while a link is up, carrier and CTS come up at once. When DTR falls, the block asks the link side to hang up with a one-cycle pulse.

The status register sits at word address 0 (`bus_addr[1]`=0) and the buffer register at word address 1. `bus_addr[0]` selects the odd byte. Register reads take effect at the clock edge of the selected cycle, and the read data is combinational.

Top module: `rxm_channel`

## Requirements
- R1: A status read returns dataset-change at bit 15, ring at 14, CTS at 13, carrier at 12, the `sec_rx` input at 10, done at 7, receive enable at 6, dataset enable at 5, secondary transmit at 3, RTS at 2 and DTR at 1. With `modem_en` low, every bit except 7 and 6 reads 0.
- R2: An even-byte status write always loads receive enable from bit 6. With `modem_en` high, the same write also loads dataset enable (bit 5), secondary transmit (bit 3), RTS (bit 2) and DTR (bit 1). `sec_tx_out`, `rts_out` and `dtr_out` show those last three bits while `modem_en` is high.
- R3: A buffer read returns error at bit 15, overrun at 14, break at 13 and the character in bits 7:0. After the read, done is 0 and `rx_req` is low.
- R4: A status read clears dataset-change, and `ds_req` is low after it, unless a dataset event happens in the same cycle.
- R5: A character that arrives while done is 1, with no buffer read in that same cycle, is stored with error and overrun set. Done stays 1.
- R6: A break stores error and break set with data 0. It follows the same done and overrun rules as a character.
- R7: `rx_req` is a registered copy of done AND receive enable. Writing the enable as 1 while done is 1 raises it on the next cycle, and writing the enable as 0 drops it.
- R8: `ds_req` is a registered copy of dataset-change AND dataset enable, gated by `modem_en`.
- R9: With modem control on, when a write takes DTR from 0 to 1 while `link_up` is high, the block clears ring and sets carrier, CTS and dataset-change.
- R10: With modem control on, when a write takes DTR from 1 to 0, the block clears carrier, ring and CTS. If the link was up, it pulses `hangup` for one cycle, and it sets dataset-change if carrier had been set.
- R11: With modem control on, a rising `link_up` sets carrier, CTS and dataset-change if DTR is 1, and otherwise sets ring and dataset-change. A low `link_up` with carrier set raises dataset-change, and a low `link_up` clears carrier, ring and CTS.
- R12: Writes to the odd status byte and to the buffer register change no state.
- R13: `por_n` low clears everything. `line_clr` high clears the buffer and status, except that DTR is kept when `modem_en` is high.
- R14: With `modem_en` low, link events and writes leave the modem bits untouched, and `ds_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| line_clr | input | 1 | Synchronous line clear |
| modem_en | input | 1 | Strap: modem control present |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | [1] register select, [0] odd byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| rx_valid | input | 1 | Character from deserializer |
| rx_break | input | 1 | Break from deserializer |
| rx_data | input | 8 | Received character |
| sec_rx | input | 1 | Secondary receive level |
| link_up | input | 1 | Remote link present |
| dtr_out | output | 1 | Data terminal ready |
| rts_out | output | 1 | Request to send |
| sec_tx_out | output | 1 | Secondary transmit |
| hangup | output | 1 | One-cycle link drop request |
| rx_req | output | 1 | Receive-ready request |
| ds_req | output | 1 | Dataset-change request |

## Verification
The hardest states to reach are the ones that need a particular order of link events and DTR writes. One example is carrier that was raised by a DTR rise on a live link and is then lost through a DTR fall, which must pulse `hangup` and flag a change. Another is a connection that arrives before DTR is set and leaves ring raised. Directed sequences build these orders explicitly. A seeded random mix of link toggles, DTR writes, characters, breaks and reads then revisits them in many interleavings against a bench-side model of the registers.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int REG_W  = 16;
  // status bit positions
  localparam int S_DSC  = 15;
  localparam int S_RING = 14;
  localparam int S_CTS  = 13;
  localparam int S_CD   = 12;
  localparam int S_SRX  = 10;
  localparam int S_DONE = 7;
  localparam int S_IE   = 6;
  localparam int S_DSIE = 5;
  localparam int S_STX  = 3;
  localparam int S_RTS  = 2;
  localparam int S_DTR  = 1;
  // buffer bit positions
  localparam int B_ERR  = 15;
  localparam int B_OVR  = 14;
  localparam int B_BRK  = 13;

  typedef struct packed {
    logic dsc, ring, cts, cd, dsie, stx, rts, dtr;
  } modem_t;

  function automatic logic [REG_W-1:0] status_word(
      input logic modem_en, input modem_t m, input logic srx,
      input logic done, input logic ie);
    logic [REG_W-1:0] w;
    w = '0;
    w[S_DONE] = done;
    w[S_IE]   = ie;
    if (modem_en) begin
      w[S_DSC]  = m.dsc;
      w[S_RING] = m.ring;
      w[S_CTS]  = m.cts;
      w[S_CD]   = m.cd;
      w[S_SRX]  = srx;
      w[S_DSIE] = m.dsie;
      w[S_STX]  = m.stx;
      w[S_RTS]  = m.rts;
      w[S_DTR]  = m.dtr;
    end
    return w;
  endfunction
endpackage

// File: rtl/rxm_decode.sv
module rxm_decode (
  input  logic       sel,
  input  logic       wr,
  input  logic [1:0] addr,
  output logic       rd_status,
  output logic       rd_buffer,
  output logic       wr_status,
  output logic       wr_ignored
);
  assign rd_status  = sel & ~wr & ~addr[1];
  assign rd_buffer  = sel & ~wr &  addr[1];
  assign wr_status  = sel &  wr & ~addr[1] & ~addr[0];
  assign wr_ignored = sel &  wr & (addr[1] | addr[0]);
endmodule

// File: rtl/rxm_holding.sv
module rxm_holding #(
  parameter int DATA_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              line_clr,
  input  logic              rx_valid,
  input  logic              rx_break,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rd_buffer,
  input  logic              wr_status,
  input  logic              w_ie,
  output logic              done_q,
  output logic              ie_q,
  output logic [REG_W-1:0]  buf_word,
  output logic              rx_req,
  output logic              overrun_evt
);
  localparam int PAD_W = REG_W - 3 - DATA_W;

  logic              ovr_q, brk_q;
  logic [DATA_W-1:0] data_q;
  logic              load, done_n, ie_n;

  assign load        = rx_valid | rx_break;
  assign overrun_evt = load & done_q & ~rd_buffer;

  always_comb begin
    done_n = done_q;
    if (rd_buffer) done_n = 1'b0;
    if (load)      done_n = 1'b1;
    ie_n = wr_status ? w_ie : ie_q;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      done_q <= 1'b0; ie_q <= 1'b0; ovr_q <= 1'b0; brk_q <= 1'b0;
      data_q <= '0;   rx_req <= 1'b0;
    end else if (line_clr) begin
      done_q <= 1'b0; ie_q <= 1'b0; ovr_q <= 1'b0; brk_q <= 1'b0;
      data_q <= '0;   rx_req <= 1'b0;
    end else begin
      done_q <= done_n;
      ie_q   <= ie_n;
      rx_req <= done_n & ie_n;
      if (load) begin
        ovr_q  <= overrun_evt;
        brk_q  <= rx_break;
        data_q <= rx_break ? '0 : rx_data;
      end
    end
  end

  assign buf_word = {ovr_q | brk_q, ovr_q, brk_q, {PAD_W{1'b0}}, data_q};
endmodule

// File: rtl/rxm_modem.sv
module rxm_modem
  import rxm_pkg::*;
(
  input  logic   clk,
  input  logic   por_n,
  input  logic   line_clr,
  input  logic   modem_en,
  input  logic   link_up,
  input  logic   rd_status,
  input  logic   wr_status,
  input  logic   w_dsie,
  input  logic   w_stx,
  input  logic   w_rts,
  input  logic   w_dtr,
  output modem_t m_q,
  output logic   ds_req,
  output logic   hangup,
  output logic   evt_conn,
  output logic   evt_dtr_rise,
  output logic   evt_dtr_fall,
  output logic   dsc_set
);
  logic   link_q, wr_m, link_down;
  modem_t m_n;

  assign wr_m         = wr_status & modem_en;
  assign evt_conn     = modem_en & link_up & ~link_q;
  assign link_down    = modem_en & ~link_up;
  assign evt_dtr_rise = wr_m &  w_dtr & ~m_q.dtr;
  assign evt_dtr_fall = wr_m & ~w_dtr &  m_q.dtr;

  always_comb begin
    m_n     = m_q;
    dsc_set = 1'b0;
    if (rd_status) m_n.dsc = 1'b0;
    if (evt_conn) begin
      dsc_set = 1'b1;
      if (m_q.dtr) begin m_n.cd = 1'b1; m_n.cts = 1'b1; end
      else m_n.ring = 1'b1;
    end
    if (link_down) begin
      if (m_q.cd) dsc_set = 1'b1;
      m_n.cd = 1'b0; m_n.ring = 1'b0; m_n.cts = 1'b0;
    end
    if (evt_dtr_rise && link_up) begin
      dsc_set = 1'b1;
      m_n.ring = 1'b0; m_n.cd = 1'b1; m_n.cts = 1'b1;
    end
    if (evt_dtr_fall) begin
      if (link_up && m_q.cd) dsc_set = 1'b1;
      m_n.cd = 1'b0; m_n.ring = 1'b0; m_n.cts = 1'b0;
    end
    if (wr_m) begin
      m_n.dsie = w_dsie; m_n.stx = w_stx; m_n.rts = w_rts; m_n.dtr = w_dtr;
    end
    if (dsc_set) m_n.dsc = 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_q <= '0; link_q <= 1'b0; ds_req <= 1'b0; hangup <= 1'b0;
    end else if (line_clr) begin
      m_q     <= '0;
      m_q.dtr <= modem_en & m_q.dtr;
      link_q  <= link_up;
      ds_req  <= 1'b0;
      hangup  <= 1'b0;
    end else begin
      m_q    <= m_n;
      link_q <= link_up;
      ds_req <= m_n.dsc & m_n.dsie & modem_en;
      hangup <= evt_dtr_fall & link_up;
    end
  end
endmodule

// File: rtl/rxm_channel.sv
module rxm_channel
  import rxm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              line_clr,
  input  logic              modem_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              rx_valid,
  input  logic              rx_break,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              sec_rx,
  input  logic              link_up,
  output logic              dtr_out,
  output logic              rts_out,
  output logic              sec_tx_out,
  output logic              hangup,
  output logic              rx_req,
  output logic              ds_req
);
  logic             rd_status, rd_buffer, wr_status, wr_ignored;
  logic             done_q, ie_q, overrun_evt;
  logic [REG_W-1:0] buf_word, stat_word;
  modem_t           m_q;
  logic             evt_conn, evt_dtr_rise, evt_dtr_fall, dsc_set;
  logic             cd_q, cts_q, ring_q, dsc_q;
  logic             unused_wbits;

  assign unused_wbits = ^{bus_wdata[REG_W-1:S_IE+1], bus_wdata[S_DSIE-1+1-1+0 +: 0+1] & 1'b0,
                          bus_wdata[S_DTR-1], overrun_evt, evt_conn};

  rxm_decode u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .rd_status(rd_status), .rd_buffer(rd_buffer),
    .wr_status(wr_status), .wr_ignored(wr_ignored)
  );

  rxm_holding #(.DATA_W(DATA_W), .REG_W(REG_W)) u_hold (
    .clk(clk), .por_n(por_n), .line_clr(line_clr),
    .rx_valid(rx_valid), .rx_break(rx_break), .rx_data(rx_data),
    .rd_buffer(rd_buffer), .wr_status(wr_status), .w_ie(bus_wdata[S_IE]),
    .done_q(done_q), .ie_q(ie_q), .buf_word(buf_word),
    .rx_req(rx_req), .overrun_evt(overrun_evt)
  );

  rxm_modem u_mdm (
    .clk(clk), .por_n(por_n), .line_clr(line_clr), .modem_en(modem_en),
    .link_up(link_up), .rd_status(rd_status), .wr_status(wr_status),
    .w_dsie(bus_wdata[S_DSIE]), .w_stx(bus_wdata[S_STX]),
    .w_rts(bus_wdata[S_RTS]), .w_dtr(bus_wdata[S_DTR]),
    .m_q(m_q), .ds_req(ds_req), .hangup(hangup),
    .evt_conn(evt_conn), .evt_dtr_rise(evt_dtr_rise),
    .evt_dtr_fall(evt_dtr_fall), .dsc_set(dsc_set)
  );

  assign cd_q   = m_q.cd;
  assign cts_q  = m_q.cts;
  assign ring_q = m_q.ring;
  assign dsc_q  = m_q.dsc;

  assign stat_word  = status_word(modem_en, m_q, sec_rx, done_q, ie_q);
  assign bus_rdata  = (bus_sel & ~bus_wr) ? (bus_addr[1] ? buf_word : stat_word) : '0;
  assign dtr_out    = m_q.dtr & modem_en;
  assign rts_out    = m_q.rts & modem_en;
  assign sec_tx_out = m_q.stx & modem_en;
endmodule

// File: rtl/rxm_channel_chk.sv
module rxm_channel_chk (
  input logic        clk,
  input logic        por_n,
  input logic        line_clr,
  input logic        modem_en,
  input logic        link_up,
  input logic        rx_valid,
  input logic        rx_break,
  input logic        rd_buffer,
  input logic        rd_status,
  input logic        wr_ignored,
  input logic        dsc_set,
  input logic        evt_dtr_rise,
  input logic        evt_dtr_fall,
  input logic        done_q,
  input logic        ie_q,
  input logic        cd_q,
  input logic        cts_q,
  input logic        ring_q,
  input logic        dsc_q,
  input logic [15:0] buf_word,
  input logic        rx_req,
  input logic        ds_req,
  input logic        hangup
);
  // R3
  buf_read_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rd_buffer && !rx_valid && !rx_break && !line_clr) |=> (!rx_req && !done_q));
  // R4
  stat_read_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rd_status && !dsc_set && !line_clr) |=> (!ds_req && !dsc_q));
  // R5
  overrun_mark_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rx_valid && !rx_break && done_q && !rd_buffer && !line_clr) |=> (buf_word[15] && buf_word[14] && done_q));
  // R6
  break_mark_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rx_break && !line_clr) |=> (buf_word[15] && buf_word[13] && buf_word[7:0] == 8'h00));
  // R9
  dtr_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
    (evt_dtr_rise && link_up && !line_clr) |=> (cd_q && cts_q && !ring_q && dsc_q));
  // R10
  hangup_start_chk: assert property (@(posedge clk) disable iff (!por_n)
    (evt_dtr_fall && link_up && !line_clr) |=> (hangup && !cd_q && !cts_q && !ring_q));
  // R10
  hangup_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    hangup |=> !hangup);
  // R12
  ignored_write_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_ignored && !rx_valid && !rx_break && !line_clr) |=> ($stable(ie_q) && $stable(done_q) && $stable(buf_word)));
  // R14
  strap_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!modem_en) |=> !ds_req);
endmodule

bind rxm_channel rxm_channel_chk i_chk (.*);

// File: tb/test_rxm_channel.sv
module test_rxm_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, line_clr = 1'b0, modem_en = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'b00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic        rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        sec_rx = 1'b0, link_up = 1'b0;
  logic        dtr_out, rts_out, sec_tx_out, hangup, rx_req, ds_req;

  int checks = 0, errors = 0;

  // bench-side model
  logic       m_done, m_ie, m_ovr, m_brk, m_dsc, m_ring, m_cts, m_cd;
  logic       m_dsie, m_stx, m_rts, m_dtr, m_link, m_hang;
  logic [7:0] m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxm_channel i_rxm_channel (
    .clk(clk), .por_n(por_n), .line_clr(line_clr), .modem_en(modem_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_break(rx_break), .rx_data(rx_data),
    .sec_rx(sec_rx), .link_up(link_up),
    .dtr_out(dtr_out), .rts_out(rts_out), .sec_tx_out(sec_tx_out),
    .hangup(hangup), .rx_req(rx_req), .ds_req(ds_req)
  );

  function automatic logic [15:0] exp_status();
    logic [15:0] s;
    s = 16'h0000;
    s[7] = m_done; s[6] = m_ie;
    if (modem_en) begin
      s[15] = m_dsc; s[14] = m_ring; s[13] = m_cts; s[12] = m_cd;
      s[10] = sec_rx; s[5] = m_dsie; s[3] = m_stx; s[2] = m_rts; s[1] = m_dtr;
    end
    return s;
  endfunction

  function automatic logic [15:0] exp_buffer();
    return {m_ovr | m_brk, m_ovr, m_brk, 5'b00000, m_data};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_done = 0; m_ie = 0; m_ovr = 0; m_brk = 0; m_data = 0; m_dsc = 0;
    m_ring = 0; m_cts = 0; m_cd = 0; m_dsie = 0; m_stx = 0; m_rts = 0;
    m_hang = 0;
  endtask

  task automatic tick_check(input string tag);
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; rx_valid = 0; rx_break = 0; line_clr = 0;
    chk({tag, " R7 rx_req"}, {15'd0, rx_req}, {15'd0, m_done & m_ie});
    chk({tag, " R8 ds_req"}, {15'd0, ds_req}, {15'd0, m_dsc & m_dsie & modem_en});
    chk({tag, " R2 pins"}, {13'd0, dtr_out, rts_out, sec_tx_out},
        {13'd0, m_dtr & modem_en, m_rts & modem_en, m_stx & modem_en});
    chk({tag, " R10 hangup"}, {15'd0, hangup}, {15'd0, m_hang});
  endtask

  task automatic op_rx(input string tag, input logic [7:0] d);
    rx_valid = 1; rx_data = d;
    m_ovr = m_done; m_brk = 0; m_data = d; m_done = 1; m_hang = 0;
    tick_check(tag);
  endtask

  task automatic op_break(input string tag);
    rx_break = 1; rx_data = 8'hA5;
    m_ovr = m_done; m_brk = 1; m_data = 0; m_done = 1; m_hang = 0;
    tick_check(tag);
  endtask

  task automatic op_rd_buf(input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = 2'b10;
    #1 chk({tag, " R3 buffer"}, bus_rdata, exp_buffer());
    m_done = 0; m_hang = 0;
    tick_check(tag);
  endtask

  task automatic op_rd_stat(input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = 2'b00;
    #1 chk({tag, " R1 status"}, bus_rdata, exp_status());
    m_dsc = 0; m_hang = 0;
    tick_check(tag);
  endtask

  task automatic op_wr_stat(input string tag, input logic [15:0] w);
    bus_sel = 1; bus_wr = 1; bus_addr = 2'b00; bus_wdata = w;
    m_hang = 0;
    m_ie = w[6];
    if (modem_en) begin
      if (w[1] && !m_dtr && m_link) begin
        m_ring = 0; m_cd = 1; m_cts = 1; m_dsc = 1;
      end
      if (!w[1] && m_dtr) begin
        if (m_link && m_cd) m_dsc = 1;
        m_hang = m_link;
        m_cd = 0; m_ring = 0; m_cts = 0;
      end
      m_dsie = w[5]; m_stx = w[3]; m_rts = w[2]; m_dtr = w[1];
    end
    tick_check(tag);
  endtask

  task automatic op_wr_ignored(input string tag, input logic [1:0] a, input logic [15:0] w);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = w; m_hang = 0;
    tick_check(tag);
  endtask

  task automatic op_link(input string tag, input logic v);
    link_up = v; m_hang = 0;
    if (modem_en) begin
      if (v && !m_link) begin
        m_dsc = 1;
        if (m_dtr) begin m_cd = 1; m_cts = 1; end
        else m_ring = 1;
      end
      if (!v) begin
        if (m_cd) m_dsc = 1;
        m_cd = 0; m_ring = 0; m_cts = 0;
      end
    end
    m_link = v;
    tick_check(tag);
  endtask

  task automatic op_clr(input string tag);
    logic keep;
    keep = modem_en & m_dtr;
    line_clr = 1;
    model_clear();
    m_dtr = keep;
    tick_check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    logic [15:0] w;
    seed = 32'h5eed;
    void'($urandom(seed));
    model_clear(); m_dtr = 0; m_link = 0;
    repeat (3) @(negedge clk);
    // R13 power-on state
    por_n = 1;
    @(negedge clk);
    op_rd_stat("R13 reset");
    op_rd_buf("R13 reset");

    // R3 R5 receive and overrun
    op_rx("R3 first", 8'h41);
    op_rd_buf("R3 read");
    op_rx("R5 a", 8'h42);
    op_rx("R5 b", 8'h43);
    op_rd_buf("R5 overrun");
    // R6 break, with and without overrun
    op_break("R6 brk");
    op_rd_buf("R6 read");
    op_rx("R6 pre", 8'h11);
    op_break("R6 brk ovr");
    op_rd_buf("R6 read ovr");
    // R7 enable with done pending, then drop
    op_rx("R7 pend", 8'h7E);
    op_wr_stat("R7 ie on", 16'h0040);
    op_wr_stat("R7 ie off", 16'h0000);
    op_wr_stat("R7 ie on2", 16'h0040);
    op_rd_buf("R7 drain");

    // R11 connection before DTR -> ring; R4 read clears; R8 late enable
    op_link("R11 conn", 1);
    op_wr_stat("R8 dsie", 16'h0020);
    op_rd_stat("R4 read ring");
    op_rd_stat("R4 reread");
    // R9 DTR rise on live link
    op_wr_stat("R9 dtr up", 16'h0026);
    op_rd_stat("R9 status");
    // R10 DTR fall on live link with carrier
    op_wr_stat("R10 dtr down", 16'h0020);
    op_rd_stat("R10 status");
    op_link("R11 drop", 0);
    // R11 connection with DTR already high, then loss
    op_wr_stat("R11 dtr", 16'h002E);
    op_link("R11 conn dtr", 1);
    op_rd_stat("R11 status");
    op_link("R11 loss", 0);
    op_rd_stat("R11 loss status");
    // R12 ignored writes
    op_rx("R12 data", 8'h5A);
    op_wr_ignored("R12 odd", 2'b01, 16'hFFFF);
    op_wr_ignored("R12 buf", 2'b10, 16'hFFFF);
    op_wr_ignored("R12 bufodd", 2'b11, 16'h0000);
    op_rd_stat("R12 status");
    op_rd_buf("R12 buffer");
    // R13 line clear keeps DTR with modem on
    op_wr_stat("R13 set", 16'h006E);
    op_rx("R13 data", 8'h33);
    op_clr("R13 clr");
    op_rd_stat("R13 kept dtr");
    op_rd_buf("R13 buf");

    // seeded random mix with modem control on
    sec_rx = 1;
    for (int i = 0; i < 1500; i++) begin
      int k;
      k = $urandom_range(0, 11);
      w = 16'($urandom());
      case (k)
        0, 1: op_rx("R5 rnd", 8'($urandom()));
        2:    op_break("R6 rnd");
        3, 4: op_rd_buf("R3 rnd");
        5:    op_rd_stat("R4 rnd");
        6, 7: op_wr_stat("R9 rnd", w);
        8:    op_link("R11 rnd", ~link_up);
        9:    op_wr_ignored("R12 rnd", {w[8], 1'b1}, w);
        10:   op_wr_ignored("R12 rnd buf", 2'b10, w);
        default: if (w[3:0] == 0) op_clr("R13 rnd"); else op_rd_stat("R1 rnd");
      endcase
    end
    op_link("R11 end", 0);

    // R14 / R2 strap off
    modem_en = 0;
    op_clr("R14 clr");
    op_wr_stat("R14 wr", 16'hFFFF);
    op_rd_stat("R14 status");
    op_link("R14 link", 1);
    op_wr_stat("R14 wr2", 16'h0002);
    op_rd_stat("R14 status2");
    op_link("R14 unlink", 0);
    op_rx("R14 rx", 8'h99);
    op_rd_stat("R14 done");
    op_rd_buf("R14 buf");
    for (int i = 0; i < 200; i++) begin
      w = 16'($urandom());
      case (w[1:0])
        2'd0: op_wr_stat("R14 rnd", w);
        2'd1: op_rd_stat("R1 off rnd");
        2'd2: op_rx("R14 rx rnd", w[15:8]);
        default: op_rd_buf("R3 off rnd");
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule